// File: doc/BRIEF.md
# Planar source clip and pointer generator

This block turns the description of one display plane's framebuffer into the per-plane fetch pointers and source sizes that a video scaler front end consumes. It accepts packed RGB layouts with a single plane, and luma/chroma layouts split into two or three planes with chroma subsampled by two horizontally, or by two in both directions. The inputs are a format code, up to three base addresses, row pitches and byte-per-pixel counts, the source width and height, and a signed on-screen position.

When the plane starts left of or above the visible area, the block removes the off-screen part. It advances each plane's pointer past the hidden pixels and rows and shrinks the luma and chroma sizes. Chroma planes use the subsampling ratio of the format, and the luma plane does not. The block reports a clamped position and emits the pointers in the order the fetch engine expects, which puts the Cr plane second for Cr-first three-plane layouts. A request is made with a one-cycle start strobe. One cycle later the block either pulses done with fresh registered results, or pulses err and leaves its previous results untouched.

Top module: `plane_clip_ptr_gen`

## Requirements
- R1: Each cycle with start high is answered exactly one cycle later by a single-cycle pulse on done or on err, never both. Neither pulses in any other cycle.
- R2: Format codes 0 to 7 are single-plane RGB. fetch_ptr[0] is plane_base[0] plus the clip advance, computed modulo 2^ADDR_W at any byte alignment. fetch_ptr[1] and fetch_ptr[2] are 0 and plane_count is 1.
- R3: Codes 8 and 10 use three planes and codes 9 and 11 use two. Pointers of unused planes are 0 and plane_count gives the number of planes.
- R4: Codes 12 to 15 are rejected with err, and every result output keeps its previous value.
- R5: With pos_x negative, plane 0 advances by plane_bpp[0]·(−pos_x) bytes. Each chroma plane advances by (plane_bpp[p]·(−pos_x)) shifted right by one, because all four chroma codes subsample horizontally.
- R6: With pos_y negative, plane 0 advances by plane_pitch[0]·(−pos_y) bytes. Each chroma plane advances by plane_pitch[p]·(−pos_y), shifted right by one for codes 8 and 9 and not shifted for codes 10 and 11.
- R7: dst_x and dst_y report 0 for a negative coordinate and the coordinate itself otherwise. A non-negative coordinate advances no pointer.
- R8: luma_w equals src_w − (−pos_x) when pos_x is negative and src_w otherwise. luma_h follows the same rule with src_h and pos_y.
- R9: chroma_w is (src_w >> h) − ((−pos_x) >> h) and chroma_h is (src_h >> v) − ((−pos_y) >> v), where h and v are the format's shifts. For RGB both shifts are 0, so the chroma sizes equal the luma sizes.
- R10: With cr_first set on a three-plane code, fetch_ptr[1] carries plane 2 and fetch_ptr[2] carries plane 1. With cr_first set on any other code, the request is rejected with err and the outputs are held.
- R11: If clipping leaves any luma or chroma width or height at zero or below, the request is rejected with err and the outputs are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe |
| fmt_code | input | 4 | Layout code (0–7 RGB, 8–11 planar) |
| cr_first | input | 1 | Cr plane stored before Cb (three-plane only) |
| plane_base | input | 3×ADDR_W | Base byte address per plane |
| plane_pitch | input | 3×PITCH_W | Row pitch in bytes per plane |
| plane_bpp | input | 3×BPP_W | Bytes per pixel per plane |
| src_w | input | DIM_W | Source width in luma pixels |
| src_h | input | DIM_W | Source height in luma rows |
| pos_x | input | POS_W | Signed on-screen X position |
| pos_y | input | POS_W | Signed on-screen Y position |
| done | output | 1 | Request accepted, results updated |
| err | output | 1 | Request rejected, results held |
| fetch_ptr | output | 3×ADDR_W | Pointers in fetch order |
| luma_w | output | DIM_W | Clipped luma width |
| luma_h | output | DIM_W | Clipped luma height |
| chroma_w | output | DIM_W | Clipped chroma width |
| chroma_h | output | DIM_W | Clipped chroma height |
| dst_x | output | POS_W-1 | Clamped X position |
| dst_y | output | POS_W-1 | Clamped Y position |
| plane_count | output | 2 | Number of planes in use |

## Verification
The hardest case to reach is a rejection caused only by the chroma size. The luma width stays positive, but truncation in the subsampled width drives the chroma width to zero. The bench reaches it with a three-pixel 4:2:0 source pushed two pixels off the left edge. Then it checks that every output still holds the previous accepted result. Odd clip amounts exercise the truncating shift in both axes, and back-to-back strobes exercise the held-output path across consecutive accepts and rejects.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
    localparam int PLANES = 3;

    typedef struct packed {
        logic       legal;
        logic [1:0] nplanes;
        logic       hsh;
        logic       vsh;
    } fmt_info_t;
endpackage

// File: rtl/pcg_fmt_decode.sv
module pcg_fmt_decode
    import pcg_pkg::*;
(
    input  logic [3:0] fmt_code,
    input  logic       cr_first,
    output fmt_info_t  info
);
    always_comb begin
        info = '{legal: 1'b0, nplanes: 2'd1, hsh: 1'b0, vsh: 1'b0};
        if (!fmt_code[3]) begin
            info.legal = !cr_first;
        end else if (fmt_code[2] == 1'b0) begin
            // bit0 selects two-plane, bit1 selects 4:2:2
            info.nplanes = fmt_code[0] ? 2'd2 : 2'd3;
            info.hsh     = 1'b1;
            info.vsh     = !fmt_code[1];
            info.legal   = !(cr_first && fmt_code[0]);
        end
    end
endmodule

// File: rtl/pcg_plane_ptr.sv
module pcg_plane_ptr #(
    parameter int ADDR_W  = 32,
    parameter int PITCH_W = 16,
    parameter int BPP_W   = 3,
    parameter int MAG_W   = 13
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [PITCH_W-1:0] pitch,
    input  logic [BPP_W-1:0]   bpp,
    input  logic [MAG_W-1:0]   negx,
    input  logic [MAG_W-1:0]   negy,
    input  logic               sub_h,
    input  logic               sub_v,
    output logic [ADDR_W-1:0]  ptr
);
    localparam int XP_W = BPP_W + MAG_W;
    localparam int YP_W = PITCH_W + MAG_W;

    logic [XP_W-1:0] xprod;
    logic [YP_W-1:0] yprod;

    always_comb begin
        xprod = XP_W'(bpp) * XP_W'(negx);
        yprod = YP_W'(pitch) * YP_W'(negy);
        ptr   = base + ADDR_W'(xprod >> sub_h) + ADDR_W'(yprod >> sub_v);
    end
endmodule

// File: rtl/pcg_size_clip.sv
module pcg_size_clip #(
    parameter int DIM_W = 12,
    parameter int MAG_W = 13
) (
    input  logic [DIM_W-1:0] src_w,
    input  logic [DIM_W-1:0] src_h,
    input  logic [MAG_W-1:0] negx,
    input  logic [MAG_W-1:0] negy,
    input  logic             hsh,
    input  logic             vsh,
    output logic [DIM_W-1:0] luma_w,
    output logic [DIM_W-1:0] luma_h,
    output logic [DIM_W-1:0] chroma_w,
    output logic [DIM_W-1:0] chroma_h,
    output logic             bad
);
    localparam int S_W = ((DIM_W > MAG_W) ? DIM_W : MAG_W) + 2;

    logic signed [S_W-1:0] lw_s, lh_s, cw_s, ch_s;

    always_comb begin
        lw_s = S_W'(src_w) - S_W'(negx);
        lh_s = S_W'(src_h) - S_W'(negy);
        cw_s = S_W'(src_w >> hsh) - S_W'(negx >> hsh);
        ch_s = S_W'(src_h >> vsh) - S_W'(negy >> vsh);
        bad  = (lw_s <= 0) || (lh_s <= 0) || (cw_s <= 0) || (ch_s <= 0);
        luma_w   = DIM_W'(lw_s);
        luma_h   = DIM_W'(lh_s);
        chroma_w = DIM_W'(cw_s);
        chroma_h = DIM_W'(ch_s);
    end
endmodule

// File: rtl/plane_clip_ptr_gen.sv
module plane_clip_ptr_gen
    import pcg_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int PITCH_W = 16,
    parameter int BPP_W   = 3,
    parameter int DIM_W   = 12,
    parameter int POS_W   = 13
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               start,
    input  logic [3:0]                         fmt_code,
    input  logic                               cr_first,
    input  logic [PLANES-1:0][ADDR_W-1:0]      plane_base,
    input  logic [PLANES-1:0][PITCH_W-1:0]     plane_pitch,
    input  logic [PLANES-1:0][BPP_W-1:0]       plane_bpp,
    input  logic [DIM_W-1:0]                   src_w,
    input  logic [DIM_W-1:0]                   src_h,
    input  logic signed [POS_W-1:0]            pos_x,
    input  logic signed [POS_W-1:0]            pos_y,
    output logic                               done,
    output logic                               err,
    output logic [PLANES-1:0][ADDR_W-1:0]      fetch_ptr,
    output logic [DIM_W-1:0]                   luma_w,
    output logic [DIM_W-1:0]                   luma_h,
    output logic [DIM_W-1:0]                   chroma_w,
    output logic [DIM_W-1:0]                   chroma_h,
    output logic [POS_W-2:0]                   dst_x,
    output logic [POS_W-2:0]                   dst_y,
    output logic [1:0]                         plane_count
);
    localparam int MAG_W = POS_W;

    typedef struct packed {
        logic                          done;
        logic                          err;
        logic [PLANES-1:0][ADDR_W-1:0] ptr;
        logic [DIM_W-1:0]              lw;
        logic [DIM_W-1:0]              lh;
        logic [DIM_W-1:0]              cw;
        logic [DIM_W-1:0]              ch;
        logic [POS_W-2:0]              x;
        logic [POS_W-2:0]              y;
        logic [1:0]                    np;
    } state_t;

    state_t st_d, st_q;

    fmt_info_t                     info;
    logic [MAG_W-1:0]              negx, negy;
    logic [PLANES-1:0][ADDR_W-1:0] raw_ptr;
    logic [DIM_W-1:0]              lw_c, lh_c, cw_c, ch_c;
    logic                          size_bad;

    always_comb begin
        negx = pos_x[POS_W-1] ? MAG_W'(-pos_x) : '0;
        negy = pos_y[POS_W-1] ? MAG_W'(-pos_y) : '0;
    end

    pcg_fmt_decode u_dec (
        .fmt_code (fmt_code),
        .cr_first (cr_first),
        .info     (info)
    );

    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        pcg_plane_ptr #(
            .ADDR_W  (ADDR_W),
            .PITCH_W (PITCH_W),
            .BPP_W   (BPP_W),
            .MAG_W   (MAG_W)
        ) u_ptr (
            .base  (plane_base[p]),
            .pitch (plane_pitch[p]),
            .bpp   (plane_bpp[p]),
            .negx  (negx),
            .negy  (negy),
            .sub_h ((p == 0) ? 1'b0 : info.hsh),
            .sub_v ((p == 0) ? 1'b0 : info.vsh),
            .ptr   (raw_ptr[p])
        );
    end

    pcg_size_clip #(
        .DIM_W (DIM_W),
        .MAG_W (MAG_W)
    ) u_size (
        .src_w    (src_w),
        .src_h    (src_h),
        .negx     (negx),
        .negy     (negy),
        .hsh      (info.hsh),
        .vsh      (info.vsh),
        .luma_w   (lw_c),
        .luma_h   (lh_c),
        .chroma_w (cw_c),
        .chroma_h (ch_c),
        .bad      (size_bad)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;
        if (start) begin
            if (info.legal && !size_bad) begin
                st_d.done   = 1'b1;
                st_d.ptr[0] = raw_ptr[0];
                st_d.ptr[1] = cr_first ? raw_ptr[2] : raw_ptr[1];
                st_d.ptr[2] = cr_first ? raw_ptr[1] : raw_ptr[2];
                for (int p = 1; p < PLANES; p++) begin
                    if (p >= int'(info.nplanes)) st_d.ptr[p] = '0;
                end
                st_d.lw = lw_c;
                st_d.lh = lh_c;
                st_d.cw = cw_c;
                st_d.ch = ch_c;
                st_d.x  = pos_x[POS_W-1] ? '0 : pos_x[POS_W-2:0];
                st_d.y  = pos_y[POS_W-1] ? '0 : pos_y[POS_W-2:0];
                st_d.np = info.nplanes;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done        = st_q.done;
    assign err         = st_q.err;
    assign fetch_ptr   = st_q.ptr;
    assign luma_w      = st_q.lw;
    assign luma_h      = st_q.lh;
    assign chroma_w    = st_q.cw;
    assign chroma_h    = st_q.ch;
    assign dst_x       = st_q.x;
    assign dst_y       = st_q.y;
    assign plane_count = st_q.np;

    assert_done_err_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));
    assert_resp_needs_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> $past(start));
    assert_start_answered_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (done || err));
    assert_hold_on_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($stable(fetch_ptr) && $stable(luma_w) && $stable(chroma_h)));
    assert_unused_ptr_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && plane_count != 2'd3) |-> (fetch_ptr[2] == '0));
    assert_chroma_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (chroma_w <= luma_w && chroma_h <= luma_h));
    assert_sizes_positive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (luma_w != '0 && luma_h != '0 && chroma_w != '0 && chroma_h != '0));
endmodule

// File: tb/plane_clip_ptr_gen_tb.sv
`timescale 1ns/1ps
module plane_clip_ptr_gen_tb;
    localparam int ADDR_W = 32, PITCH_W = 16, BPP_W = 3, DIM_W = 12, POS_W = 13;
    localparam longint AMASK = (64'd1 << ADDR_W) - 1;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cr_first = 1'b0;
    logic [3:0] fmt_code = '0;
    logic [2:0][ADDR_W-1:0]  plane_base = '0;
    logic [2:0][PITCH_W-1:0] plane_pitch = '0;
    logic [2:0][BPP_W-1:0]   plane_bpp = '0;
    logic [DIM_W-1:0] src_w = '0, src_h = '0;
    logic signed [POS_W-1:0] pos_x = '0, pos_y = '0;
    logic done, err;
    logic [2:0][ADDR_W-1:0] fetch_ptr;
    logic [DIM_W-1:0] luma_w, luma_h, chroma_w, chroma_h;
    logic [POS_W-2:0] dst_x, dst_y;
    logic [1:0] plane_count;

    always #10 clk = ~clk;

    plane_clip_ptr_gen u_dut (.*);

    typedef struct {
        bit     err;
        longint ptr [3];
        int     lw, lh, cw, ch, x, y, np;
        string  tag;
    } exp_t;

    exp_t   sb_q[$];
    exp_t   held;
    int     checks = 0, errors = 0;

    task automatic chk(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Scoreboard driver: model from the requirements, push, strobe start
    task automatic run(string tag, int fmt, bit cr, longint b0, longint b1, longint b2,
                       int p0, int p1, int p2, int q0, int q1, int q2,
                       int sw, int sh, int px, int py);
        exp_t e;
        int np, hs, vs, nx, ny;
        bit legal;
        longint b[3];
        int pi[3], bp[3];
        b = '{b0, b1, b2}; pi = '{p0, p1, p2}; bp = '{q0, q1, q2};
        legal = 1; np = 1; hs = 0; vs = 0;
        if (fmt >= 12) legal = 0;
        else if (fmt >= 8) begin
            np = (fmt == 8 || fmt == 10) ? 3 : 2;
            hs = 1;
            vs = (fmt == 8 || fmt == 9) ? 1 : 0;
        end
        if (cr && np != 3) legal = 0;
        nx = (px < 0) ? -px : 0;
        ny = (py < 0) ? -py : 0;
        e = held;
        e.tag = tag;
        e.lw = sw - nx; e.lh = sh - ny;
        e.cw = (sw >> hs) - (nx >> hs); e.ch = (sh >> vs) - (ny >> vs);
        if (e.lw <= 0 || e.lh <= 0 || e.cw <= 0 || e.ch <= 0) legal = 0;
        if (!legal) begin
            e = held; e.tag = tag; e.err = 1;
        end else begin
            longint r[3];
            for (int p = 0; p < 3; p++) begin
                longint xo, yo;
                xo = longint'(bp[p]) * nx;
                yo = longint'(pi[p]) * ny;
                if (p > 0) begin xo = xo >> hs; yo = yo >> vs; end
                r[p] = (p < np) ? ((b[p] + xo + yo) & AMASK) : 0;
            end
            e.err = 0;
            e.ptr[0] = r[0];
            e.ptr[1] = cr ? r[2] : r[1];
            e.ptr[2] = cr ? r[1] : r[2];
            e.x = (px < 0) ? 0 : px;
            e.y = (py < 0) ? 0 : py;
            e.np = np;
            held = e;
        end
        sb_q.push_back(e);
        fmt_code = 4'(fmt); cr_first = cr;
        plane_base[0] = ADDR_W'(b0); plane_base[1] = ADDR_W'(b1); plane_base[2] = ADDR_W'(b2);
        plane_pitch[0] = PITCH_W'(p0); plane_pitch[1] = PITCH_W'(p1); plane_pitch[2] = PITCH_W'(p2);
        plane_bpp[0] = BPP_W'(q0); plane_bpp[1] = BPP_W'(q1); plane_bpp[2] = BPP_W'(q2);
        src_w = DIM_W'(sw); src_h = DIM_W'(sh);
        pos_x = POS_W'(px); pos_y = POS_W'(py);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Monitor: pop and compare on every response
    always @(negedge clk) begin
        if (rst_n && (done || err)) begin
            if (sb_q.size() == 0) begin
                chk("R1", "unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(e.tag, "done", done, !e.err);
                chk(e.tag, "err", err, e.err);
                for (int p = 0; p < 3; p++) chk(e.tag, $sformatf("ptr%0d", p), fetch_ptr[p], e.ptr[p]);
                chk(e.tag, "luma_w", luma_w, e.lw);
                chk(e.tag, "luma_h", luma_h, e.lh);
                chk(e.tag, "chroma_w", chroma_w, e.cw);
                chk(e.tag, "chroma_h", chroma_h, e.ch);
                chk(e.tag, "dst_x", dst_x, e.x);
                chk(e.tag, "dst_y", dst_y, e.y);
                chk(e.tag, "planes", plane_count, e.np);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        held = '{err: 0, ptr: '{0, 0, 0}, lw: 0, lh: 0, cw: 0, ch: 0, x: 0, y: 0, np: 0, tag: ""};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R1 idle, all results zero)
        chk("R1", "reset done", done, 0);
        chk("R1", "reset err", err, 0);
        chk("R2", "reset ptr0", fetch_ptr[0], 0);
        chk("R8", "reset luma_w", luma_w, 0);

        run("R2", 7, 0, 64'h1000_0000, 0, 0, 7680, 0, 0, 4, 0, 0, 640, 480, 10, 20);
        run("R5", 3, 0, 64'h2000_0001, 0, 0, 333, 0, 0, 2, 0, 0, 320, 240, -5, -3);
        run("R3", 8, 0, 64'h3000_0000, 64'h3100_0000, 64'h3200_0000, 720, 360, 360, 1, 1, 1, 720, 576, -7, -5);
        run("R3", 9, 0, 64'h4000_0000, 64'h4100_0003, 0, 1920, 1920, 0, 1, 2, 0, 1920, 1080, -6, -4);
        run("R6", 10, 0, 64'h5000_0000, 64'h5100_0000, 64'h5200_0000, 640, 321, 321, 1, 1, 1, 640, 480, -3, -3);
        run("R5", 11, 0, 64'h6000_0000, 64'h6100_0000, 0, 800, 800, 0, 1, 2, 0, 800, 600, -9, 0);
        run("R10", 10, 1, 64'h7000_0000, 64'h7100_0000, 64'h7200_0000, 640, 320, 320, 1, 1, 1, 640, 480, -4, -2);
        run("R10", 9, 1, 64'h7300_0000, 64'h7400_0000, 0, 640, 640, 0, 1, 2, 0, 640, 480, 0, 0);
        run("R4", 12, 0, 64'h1, 0, 0, 64, 0, 0, 4, 0, 0, 16, 16, 0, 0);
        run("R4", 15, 0, 64'h2, 0, 0, 64, 0, 0, 4, 0, 0, 16, 16, 0, 0);
        run("R11", 7, 0, 64'h100, 0, 0, 64, 0, 0, 4, 0, 0, 4, 8, -4, 0);
        run("R11", 8, 0, 64'h200, 64'h300, 64'h400, 16, 8, 8, 1, 1, 1, 3, 8, -2, 0);
        run("R11", 8, 0, 64'h200, 64'h300, 64'h400, 16, 8, 8, 1, 1, 1, 8, 2, 0, -2);
        run("R8", 7, 0, 64'h500, 0, 0, 64, 0, 0, 4, 0, 0, 4, 8, -3, 0);
        run("R2", 7, 0, 64'hFFFF_FFF0, 0, 0, 64, 0, 0, 4, 0, 0, 100, 100, -8, 0);
        run("R7", 8, 0, 64'h8000_0000, 64'h8100_0000, 64'h8200_0000, 720, 360, 360, 1, 1, 1, 720, 576, 100, 50);
        run("R11", 7, 0, 64'h600, 0, 0, 64, 0, 0, 1, 0, 0, 4095, 10, -4096, 0);
        run("R9", 8, 0, 64'h9000_0000, 64'h9100_0000, 64'h9200_0000, 33, 17, 17, 1, 1, 1, 7, 5, -3, -1);
        @(negedge clk);
        // idle cycles: no response without a start (R1)
        for (int i = 0; i < 4; i++) begin
            chk("R1", "idle done", done, 0);
            chk("R1", "idle err", err, 0);
            @(negedge clk);
        end
        chk("R1", "pending responses", sb_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule